// File: doc/BRIEF.md
# Byte-Wide Timer Register Interface

This block is the 8-bit register front end of a three-channel, 16-bit interval timer. A 2-bit address selects one of three channel data ports (0, 1, 2) or the control port (3). Control words set a channel's operating mode, BCD flag and byte access mode, or ask for a count or status snapshot. Data writes are assembled into a 16-bit reload value. That value goes out to the counting logic with a one-cycle load strobe. Data reads return the channel's count one byte at a time.

The counting logic sits outside this block. It supplies each channel's live 16-bit count and output pin level. It receives the reload value, the mode, the BCD flag and the load strobe. Each channel has its own write byte sequencer, read byte pointer, one-shot count latch and one-shot status latch.

Top module: `tmr_port_if`

## Requirements
- R1: After reset, every reload value is 0, every mode and BCD output is 0, no load strobe is high, and a channel read returns the live count, low byte first.
- R2: A control word with select bits 7:6 equal to 0, 1 or 2 and a nonzero access field (bits 5:4) programs that channel. The word sets the mode from bits 3:1 and the BCD flag from bit 0, and returns both the write sequencer and the read pointer to the low byte.
- R3: With access 1 (low only), a data write replaces only bits 7:0 of the reload value. The load strobe pulses in the cycle after the write.
- R4: With access 2 (high only), a data write replaces only bits 15:8 of the reload value. The load strobe pulses in the cycle after the write.
- R5: With access 3 (low then high), the first data write sets the low byte and gives no strobe. The second sets the high byte and gives the strobe. The following write is again taken as a low byte.
- R6: Data reads alternate between the low byte and the high byte. The byte appears on the read data output in the cycle after the read.
- R7: A control word with access field 0 latches the selected channel's live count, unless a count is already latched. The latched value is returned until its high byte has been read, and the latch is then released.
- R8: A control word with select bits 7:6 equal to 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 low latches the count and bit 4 low latches the status of each selected channel.
- R9: The status byte is laid out as bit 7 output pin, bit 6 null flag, bits 5:4 access, bits 3:1 mode and bit 0 BCD. A latched status is returned by the next read ahead of any count byte and is then released. A status latch request is ignored while a status is already latched.
- R10: Programming a channel sets its null flag. Each load strobe clears it.
- R11: A read of the control address returns 0x00. Data writes to a channel whose access field is still 0 are ignored: the reload value is unchanged and no strobe fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Port select: 0..2 channel data, 3 control |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read |
| live_count | input | 48 | Live counts, channel i in bits 16i+15:16i |
| chan_out | input | 3 | Output pin level of each channel |
| reload_val | output | 48 | Reload values, channel i in bits 16i+15:16i |
| op_mode | output | 9 | Operating modes, channel i in bits 3i+2:3i |
| bcd_mode | output | 3 | BCD flag of each channel |
| load_stb | output | 3 | One-cycle pulse when a reload value is complete |

## Verification
Every result of this block is due exactly one clock edge after the bus strobe that causes it. Reload values and load strobes change on the edge that samples the write. Read data is registered on the edge that samples the read, and latches capture the live count on the edge that samples the command. The bench drives the strobes on falling edges. It checks strobes and reload values on the falling edge that follows the sampling rising edge. It queues each expected read byte when it issues the read, and a monitor pops the queue on the falling edge after a read was seen, so every comparison happens half a cycle after its edge.

// File: rtl/tmr_port_pkg.sv
package tmr_port_pkg;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_LOHI  = 2'd3
  } acc_e;

  localparam logic [1:0] SEL_READBACK = 2'd3;

  // Status byte: out, null, access, mode, bcd (MSB to LSB)
  function automatic logic [7:0] status_byte(input logic out_pin, input logic null_f,
                                             input logic [1:0] acc, input logic [2:0] mode,
                                             input logic bcd);
    return {out_pin, null_f, acc, mode, bcd};
  endfunction

  // Byte of a 16-bit word chosen by a high/low pointer
  function automatic logic [7:0] pick_byte(input logic [15:0] word, input logic hi);
    return hi ? word[15:8] : word[7:0];
  endfunction

  // Replace one byte of a 16-bit word
  function automatic logic [15:0] put_byte(input logic [15:0] word, input logic [7:0] b,
                                           input logic hi);
    return hi ? {b, word[7:0]} : {word[15:8], b};
  endfunction

endpackage

// File: rtl/tmr_cw_decode.sv
module tmr_cw_decode
  import tmr_port_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic [1:0]     addr,
  input  logic           wr,
  input  logic           rd,
  input  logic [7:0]     wdata,
  output logic [NCH-1:0] prog,
  output logic [NCH-1:0] lat_cnt,
  output logic [NCH-1:0] lat_sts,
  output logic [NCH-1:0] data_wr,
  output logic [NCH-1:0] data_rd
);

  logic       ctrl_wr;
  logic [1:0] sel;
  logic [1:0] acc;

  assign ctrl_wr = wr && (addr == 2'd3);
  assign sel     = wdata[7:6];
  assign acc     = wdata[5:4];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic direct_hit;
    logic rb_hit;
    assign direct_hit = ctrl_wr && (sel == 2'(i));
    assign rb_hit     = ctrl_wr && (sel == SEL_READBACK) && wdata[1+i];
    assign prog[i]    = direct_hit && (acc != ACC_LATCH);
    assign lat_cnt[i] = (direct_hit && (acc == ACC_LATCH)) || (rb_hit && !wdata[5]);
    assign lat_sts[i] = rb_hit && !wdata[4];
    assign data_wr[i] = wr && (addr == 2'(i));
    assign data_rd[i] = rd && (addr == 2'(i));
  end

endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
  import tmr_port_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog,
  input  logic [2:0]    prog_mode,
  input  logic [1:0]    prog_acc,
  input  logic          prog_bcd,
  input  logic          lat_cnt,
  input  logic          lat_sts,
  input  logic          data_wr,
  input  logic [7:0]    wdata,
  input  logic          data_rd,
  input  logic [DW-1:0] live_cnt,
  input  logic          out_pin,
  output logic [DW-1:0] reload,
  output logic [2:0]    mode,
  output logic          bcd,
  output logic          load_stb,
  output logic [7:0]    rd_byte
);

  logic [1:0]    acc;
  logic          wr_hi;
  logic          rd_hi;
  logic          null_f;
  logic          cnt_lat;
  logic [DW-1:0] cnt_hold;
  logic          sts_lat;
  logic [7:0]    sts_hold;
  logic          load_now;
  logic          byte_hi;

  // which byte this data write touches and whether it completes the value
  always_comb begin
    load_now = 1'b0;
    byte_hi  = 1'b0;
    unique case (acc)
      ACC_LO:   begin byte_hi = 1'b0;  load_now = 1'b1;  end
      ACC_HI:   begin byte_hi = 1'b1;  load_now = 1'b1;  end
      ACC_LOHI: begin byte_hi = wr_hi; load_now = wr_hi; end
      default:  begin byte_hi = 1'b0;  load_now = 1'b0;  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= ACC_LATCH;
      mode     <= '0;
      bcd      <= 1'b0;
      reload   <= '0;
      wr_hi    <= 1'b0;
      rd_hi    <= 1'b0;
      null_f   <= 1'b0;
      cnt_lat  <= 1'b0;
      cnt_hold <= '0;
      sts_lat  <= 1'b0;
      sts_hold <= '0;
      load_stb <= 1'b0;
    end else begin
      load_stb <= 1'b0;
      if (prog) begin
        acc    <= prog_acc;
        mode   <= prog_mode;
        bcd    <= prog_bcd;
        wr_hi  <= 1'b0;
        rd_hi  <= 1'b0;
        null_f <= 1'b1;
      end
      if (lat_cnt && !cnt_lat) begin
        cnt_hold <= live_cnt;
        cnt_lat  <= 1'b1;
      end
      if (lat_sts && !sts_lat) begin
        sts_hold <= status_byte(out_pin, null_f, acc, mode, bcd);
        sts_lat  <= 1'b1;
      end
      if (data_wr && (acc != ACC_LATCH)) begin
        reload <= put_byte(reload, wdata, byte_hi);
        if (acc == ACC_LOHI) wr_hi <= !wr_hi;
        if (load_now) begin
          load_stb <= 1'b1;
          null_f   <= 1'b0;
        end
      end
      if (data_rd) begin
        if (sts_lat) begin
          sts_lat <= 1'b0;
        end else begin
          rd_hi <= !rd_hi;
          if (rd_hi && cnt_lat) cnt_lat <= 1'b0;
        end
      end
    end
  end

  assign rd_byte = sts_lat ? sts_hold : pick_byte(cnt_lat ? cnt_hold : live_cnt, rd_hi);

  // R3
  load_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> $past(data_wr));
  // R5
  wr_seq_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |-> (acc == ACC_LOHI));
  // R7
  latch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnt_lat) |-> $past(data_rd && rd_hi && !sts_lat));
  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_lat && $past(cnt_lat)) |-> $stable(cnt_hold));
  // R10
  null_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> !null_f);

endmodule

// File: rtl/tmr_port_if.sv
module tmr_port_if
  import tmr_port_pkg::*;
#(
  parameter int NCH = 3,
  parameter int DW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [NCH*DW-1:0] live_count,
  input  logic [NCH-1:0]    chan_out,
  output logic [NCH*DW-1:0] reload_val,
  output logic [NCH*3-1:0]  op_mode,
  output logic [NCH-1:0]    bcd_mode,
  output logic [NCH-1:0]    load_stb
);

  logic [NCH-1:0] prog, lat_cnt, lat_sts, data_wr, data_rd;
  logic [7:0]     rd_bytes [NCH];
  logic [7:0]     rd_next;

  tmr_cw_decode #(.NCH(NCH)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .wdata(bus_wdata),
    .prog(prog), .lat_cnt(lat_cnt), .lat_sts(lat_sts),
    .data_wr(data_wr), .data_rd(data_rd)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_chan_port #(.DW(DW)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .prog(prog[i]), .prog_mode(bus_wdata[3:1]), .prog_acc(bus_wdata[5:4]),
      .prog_bcd(bus_wdata[0]),
      .lat_cnt(lat_cnt[i]), .lat_sts(lat_sts[i]),
      .data_wr(data_wr[i]), .wdata(bus_wdata), .data_rd(data_rd[i]),
      .live_cnt(live_count[i*DW +: DW]), .out_pin(chan_out[i]),
      .reload(reload_val[i*DW +: DW]), .mode(op_mode[i*3 +: 3]),
      .bcd(bcd_mode[i]), .load_stb(load_stb[i]), .rd_byte(rd_bytes[i])
    );
  end

  always_comb begin
    rd_next = 8'h00;
    for (int i = 0; i < NCH; i++)
      if (bus_addr == 2'(i)) rd_next = rd_bytes[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= 8'h00;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  // R11
  ctrl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd3) |=> (bus_rdata == 8'h00));
  // R6
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(bus_rd) && $past(rst_n)) |-> $stable(bus_rdata));

endmodule

// File: tb/tmr_port_if_tb.sv
module tmr_port_if_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [47:0] live_count = '0;
  logic [2:0]  chan_out = '0;
  logic [47:0] reload_val;
  logic [8:0]  op_mode;
  logic [2:0]  bcd_mode, load_stb;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always #2 clk = ~clk;

  tmr_port_if u_dut (.*);

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: compare read data half a cycle after the sampling edge
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R6 unexpected read actual=%0h expected=none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    live_count = {16'h0000, 16'h0000, 16'h1234};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reload", reload_val, 48'h0);
    check("R1 mode", op_mode, 9'h0);
    check("R1 strobe", load_stb, 3'h0);
    rd(2'd0, 8'h34, "R1 first read low");
    rd(2'd0, 8'h12, "R6 second read high");
    // R11: unprogrammed channel ignores data
    wr(2'd2, 8'hFF);
    check("R11 no strobe", load_stb, 3'h0);
    check("R11 reload kept", reload_val[47:32], 16'h0);
    rd(2'd3, 8'h00, "R11 control read");
    // R2: ch0 access3 mode2 bcd1
    chan_out = 3'b001;
    wr(2'd3, 8'h35);
    check("R2 mode", op_mode[2:0], 3'd2);
    check("R2 bcd", bcd_mode[0], 1'b1);
    wr(2'd3, 8'hE2);
    rd(2'd0, 8'hF5, "R9 R10 status null set");
    rd(2'd0, 8'h34, "R9 count after status");
    rd(2'd0, 8'h12, "R6 high after status");
    // R5
    wr(2'd0, 8'hCD);
    check("R5 no strobe on low", load_stb, 3'h0);
    wr(2'd0, 8'hAB);
    check("R5 strobe on high", load_stb, 3'b001);
    check("R5 reload", reload_val[15:0], 16'hABCD);
    @(negedge clk);
    check("R5 strobe one cycle", load_stb, 3'h0);
    wr(2'd3, 8'hE2);
    rd(2'd0, 8'hB5, "R10 null cleared");
    wr(2'd0, 8'h11);
    check("R5 restart low", load_stb, 3'h0);
    wr(2'd0, 8'h22);
    check("R5 second value", reload_val[15:0], 16'h2211);
    // R3 / R4
    wr(2'd3, 8'h50);
    wr(2'd1, 8'h77);
    check("R3 strobe", load_stb, 3'b010);
    check("R3 reload", reload_val[31:16], 16'h0077);
    wr(2'd3, 8'hA8);
    check("R2 mode ch2", op_mode[8:6], 3'd4);
    wr(2'd2, 8'h99);
    check("R4 strobe", load_stb, 3'b100);
    check("R4 reload", reload_val[47:32], 16'h9900);
    wr(2'd1, 8'h55);
    check("R3 low only", reload_val[31:16], 16'h0055);
    // R7 latch
    live_count[31:16] = 16'h4321;
    wr(2'd3, 8'h40);
    live_count[31:16] = 16'h1111;
    wr(2'd3, 8'h40);
    rd(2'd1, 8'h21, "R7 latched low");
    live_count[31:16] = 16'h5678;
    rd(2'd1, 8'h43, "R7 latched high");
    rd(2'd1, 8'h78, "R7 released low");
    rd(2'd1, 8'h56, "R7 released high");
    // R8 read-back count latch ch0 and ch2
    live_count[15:0] = 16'h0102; live_count[47:32] = 16'h0304;
    wr(2'd3, 8'hDA);
    live_count[15:0] = 16'hFFFF; live_count[47:32] = 16'hEEEE;
    rd(2'd2, 8'h04, "R8 ch2 low");
    rd(2'd2, 8'h03, "R8 ch2 high");
    rd(2'd0, 8'h02, "R8 ch0 low");
    rd(2'd0, 8'h01, "R8 ch0 high");
    // R9 second status latch ignored
    chan_out = 3'b000;
    wr(2'd3, 8'hE8);
    chan_out = 3'b100;
    wr(2'd3, 8'hE8);
    rd(2'd2, 8'h28, "R9 first status kept");
    rd(2'd2, 8'hEE, "R9 released to count");
    repeat (2) @(negedge clk);
    check("R6 queue drained", 48'(exp_q.size()), 48'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule